// File: doc/BRIEF.md
# Flash Sector-Erase Command Sequencer

This block sits on the bus side of a NOR-style flash and turns a stream of single-cycle write strobes into sector-erase work. It follows a six-write command sequence. Once that sequence has been accepted it records the target sector in a selection mask and opens an accumulation window. Further erase-command writes that arrive before the window closes add more sectors. When the window runs out with no further write, the block walks the selected sectors from the lowest index upwards. For each sector it first asks the array back-end to preprogram the sector and then to erase it, using a request/done handshake for each step.

While the operation runs, the block drives a ready/busy output and a status byte. The status byte carries an inverted-data poll bit and a toggle bit that flips on every status read. During the erase phase the only command honoured is suspend. A suspend holds the walk at the next step boundary, and a later erase-command write resumes it. When the walk finishes, the mask is cleared and the block returns to read-array mode.

Writes are sampled on the clock edge at which `wr_en` is high, so the address and the data of one bus cycle are taken together. The window length is given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset `ready` is 1, `eng_req` is 0 and `status` is 8'h80.
- R2: The writes (addr low 11 bits = 555h, data AAh), (2AAh, 55h), (555h, 80h), (555h, AAh), (2AAh, 55h), followed by data 30h at any address, select the sector given by address bits [13:11] and drop `ready` to 0 at the clock edge of that last write.
- R3: A write that does not match the next expected step of the sequence sends the decoder back to idle. No sector is selected and `ready` stays 1.
- R4: While the window is open, each write of data 30h adds the sector given by its address bits [13:11]. Sectors may be added in any order.
- R5: Any write while the window is open restarts the window. `eng_req` first rises TIMEOUT_CYCLES+1 edges after the edge of the last write.
- R6: Each selected sector is handled in ascending index order. The preprogram step (`eng_op`=0) comes first and the erase step (`eng_op`=1) second. `eng_req`, `eng_sector` and `eng_op` are held until `eng_done`.
- R7: A sector whose `protect` bit is 1 when its command is written is never selected. If no sector is selected when the window closes, the block returns to ready without issuing any request.
- R8: During the erase phase, every write other than data B0h is ignored. A B0h write suspends the walk at the next step boundary: `eng_req` stays 0 and `ready` reads 1. A later write of 30h resumes the walk.
- R9: `status[7]` is 0 while busy and 1 while ready. `status[6]` flips on each `rd_en` while busy and holds while ready. `status[5:0]` is 0.
- R10: When the walk completes, `ready` returns to 1 and the selection mask is empty, so a later sequence erases only its own sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One bus write, sampled on the clock edge |
| wr_addr | input | ADDR_W (14) | Write address; the top bits give the sector |
| wr_data | input | 8 | Write data / command byte |
| rd_en | input | 1 | One status read |
| protect | input | NUM_SECTORS (8) | Per-sector write protection |
| eng_done | input | 1 | Back-end has finished the current step |
| ready | output | 1 | 1 = ready, 0 = busy |
| status | output | 8 | Poll bit [7], toggle bit [6], zeros below |
| eng_req | output | 1 | Step request, held until `eng_done` |
| eng_op | output | 1 | 0 = preprogram, 1 = erase |
| eng_sector | output | SEC_W (3) | Sector for the current step |

## Verification
The last sequence write shows up on `ready` at the edge that samples it, so the bench reads `ready` at the falling edge right after that edge. A status read changes the toggle bit at its own edge and is read back the same way. The first request is due exactly TIMEOUT_CYCLES+1 edges after the last window write. The bench counts falling edges from that write and checks that `eng_req` is still low one edge early and high on the due edge; a restart write placed inside the window moves that edge, and the check follows it. Handshake results carry no fixed latency: a scoreboard queue holds the expected (step, sector) pairs, and the responder model pops one and compares it when it sees a request.

// File: rtl/fes_pkg.sv
// Package: shared types and command codes for the sector-erase sequencer.
// Assumes an 8-bit command byte and unlock addresses compared on the low
// address bits only.
package fes_pkg;
    typedef enum logic [2:0] {
        D_IDLE, D_C1, D_C2, D_SETUP, D_C4, D_C5
    } dec_state_t;

    typedef enum logic [1:0] {
        M_READ, M_WINDOW, M_RUN, M_SUSP
    } mode_t;

    typedef enum logic {
        E_PICK, E_WAIT
    } eng_state_t;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam int         ADDR_KEY_A  = 'h555;
    localparam int         ADDR_KEY_B  = 'h2AA;
    localparam logic       OP_PRE      = 1'b0;
    localparam logic       OP_ERS      = 1'b1;
endpackage

// File: rtl/fes_cmd_decoder.sv
// Module: unlock and erase-command decoder.
// Follows the five lead-in writes and flags the sixth write when it carries
// the sector command. Any mismatch returns it to idle. It is held idle
// whenever enable is low.
module fes_cmd_decoder
    import fes_pkg::*;
#(
    parameter int UNLOCK_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                wr_en,
    input  logic [UNLOCK_W-1:0] addr_lo,
    input  logic [7:0]          data,
    output logic                seq_hit
);
    dec_state_t st;
    logic is_a, is_b, is_setup;

    // Match the address/data pairs of the lead-in writes.
    always_comb begin
        is_a     = (addr_lo == UNLOCK_W'(ADDR_KEY_A)) && (data == CMD_KEY_A);
        is_b     = (addr_lo == UNLOCK_W'(ADDR_KEY_B)) && (data == CMD_KEY_B);
        is_setup = (addr_lo == UNLOCK_W'(ADDR_KEY_A)) && (data == CMD_SETUP);
    end

    // The final write completes the sequence; its address is free.
    assign seq_hit = enable && wr_en && (st == D_C5) && (data == CMD_SECTOR);

    // Advance one step per matching write, fall back to idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            st <= D_IDLE;
        end else if (wr_en) begin
            case (st)
                D_IDLE:  st <= is_a     ? D_C1    : D_IDLE;
                D_C1:    st <= is_b     ? D_C2    : D_IDLE;
                D_C2:    st <= is_setup ? D_SETUP : D_IDLE;
                D_SETUP: st <= is_a     ? D_C4    : D_IDLE;
                D_C4:    st <= is_b     ? D_C5    : D_IDLE;
                default: st <= D_IDLE;
            endcase
        end
    end

    assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_en && st == D_C1 && data != CMD_KEY_B) |=> st == D_IDLE);
    assert_hit_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_hit |=> st == D_IDLE);
endmodule

// File: rtl/fes_window_timer.sv
// Module: accumulation window timer.
// Loads CYCLES-1 on restart and counts down. It signals expiry for exactly
// one cycle, and never in a cycle where a restart arrives.
// Assumes CYCLES >= 2.
module fes_window_timer #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic active,
    output logic expire
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    logic [CW-1:0] cnt;

    // Reload on restart, otherwise count down while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (restart) begin
            cnt    <= CW'(CYCLES - 1);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign expire = active && (cnt == '0) && !restart;

    assert_expire_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
    assert_restart_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (active && !expire));
endmodule

// File: rtl/fes_sector_mask.sv
// Module: sector selection mask.
// One bit per sector. A protected sector is never set. The block reports
// whether any bit is set and the index of the lowest set bit.
module fes_sector_mask #(
    parameter int N = 8,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [SW-1:0] set_idx,
    input  logic [N-1:0]  protect,
    input  logic          clr_en,
    input  logic [SW-1:0] clr_idx,
    input  logic          clr_all,
    output logic [N-1:0]  bits,
    output logic          any,
    output logic [SW-1:0] low_idx
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic q;

        // Per-sector flag: set by an unprotected command, cleared when erased.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)                                 q <= 1'b0;
            else if (set_en && set_idx == SW'(g) && !protect[g])  q <= 1'b1;
            else if (clr_en && clr_idx == SW'(g))                 q <= 1'b0;
        end
        assign bits[g] = q;

        assert_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && set_idx == SW'(g) && protect[g] && !q) |=> !q);
    end

    // Lowest set bit wins.
    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) low_idx = SW'(i);
        end
    end

    assign any = |bits;
endmodule

// File: rtl/flash_erase_seq.sv
// Module: top of the sector-erase sequencer.
// Owns the mode FSM (read, window, run, suspend), the per-sector
// preprogram/erase walk and the status outputs. Assumes a back-end that
// answers each held eng_req with a one-cycle eng_done.
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int NUM_SECTORS = 8,
    parameter int UNLOCK_W    = 11,
    parameter int CLK_MHZ     = 125,
    parameter int WINDOW_US   = 80,
    parameter int SEC_W       = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
    parameter int ADDR_W      = UNLOCK_W + SEC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   rd_en,
    input  logic [NUM_SECTORS-1:0] protect,
    input  logic                   eng_done,
    output logic                   ready,
    output logic [7:0]             status,
    output logic                   eng_req,
    output logic                   eng_op,
    output logic [SEC_W-1:0]       eng_sector
);
    localparam int TIMEOUT_CYCLES = CLK_MHZ * WINDOW_US;

    mode_t            mode;
    eng_state_t       estate;
    logic             step;
    logic             susp_pend;
    logic             tog;
    logic             seq_hit, win_wr, win_add, restart, expire, win_active;
    logic             set_en, clr_en, clr_all, any;
    logic [SEC_W-1:0] wr_sec, low_idx;
    logic [NUM_SECTORS-1:0] mask_bits;

    assign wr_sec = wr_addr[ADDR_W-1:UNLOCK_W];

    fes_cmd_decoder #(.UNLOCK_W(UNLOCK_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode == M_READ),
        .wr_en   (wr_en),
        .addr_lo (wr_addr[UNLOCK_W-1:0]),
        .data    (wr_data),
        .seq_hit (seq_hit)
    );

    // Window activity: every write restarts, a 30h write also adds a sector.
    always_comb begin
        win_wr  = (mode == M_WINDOW) && wr_en;
        win_add = win_wr && (wr_data == CMD_SECTOR);
        restart = seq_hit || win_wr;
        set_en  = seq_hit || win_add;
        clr_en  = (estate == E_WAIT) && eng_done && (eng_op == OP_ERS);
        clr_all = (mode == M_RUN) && (estate == E_PICK) && !any;
    end

    fes_window_timer #(.CYCLES(TIMEOUT_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .active  (win_active),
        .expire  (expire)
    );

    fes_sector_mask #(.N(NUM_SECTORS), .SW(SEC_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_idx (wr_sec),
        .protect (protect),
        .clr_en  (clr_en),
        .clr_idx (eng_sector),
        .clr_all (clr_all),
        .bits    (mask_bits),
        .any     (any),
        .low_idx (low_idx)
    );

    // Mode FSM: read -> window -> run (<-> suspend) -> read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= M_READ;
        end else begin
            case (mode)
                M_READ:   if (seq_hit) mode <= M_WINDOW;
                M_WINDOW: if (expire)  mode <= M_RUN;
                M_RUN: begin
                    if (estate == E_PICK) begin
                        if (!any)          mode <= M_READ;
                        else if (susp_pend) mode <= M_SUSP;
                    end
                end
                default:  if (wr_en && wr_data == CMD_SECTOR) mode <= M_RUN;
            endcase
        end
    end

    // Suspend request: latched in run, consumed at the next step boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || mode != M_RUN)
            susp_pend <= 1'b0;
        else if (wr_en && wr_data == CMD_SUSPEND)
            susp_pend <= 1'b1;
    end

    // Sector walk: preprogram then erase the lowest selected sector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            estate     <= E_PICK;
            step       <= OP_PRE;
            eng_req    <= 1'b0;
            eng_op     <= OP_PRE;
            eng_sector <= '0;
        end else if (estate == E_PICK) begin
            if (mode == M_RUN && any && !susp_pend) begin
                eng_req    <= 1'b1;
                eng_op     <= step;
                eng_sector <= low_idx;
                estate     <= E_WAIT;
            end
        end else if (eng_done) begin
            eng_req <= 1'b0;
            step    <= (eng_op == OP_PRE) ? OP_ERS : OP_PRE;
            estate  <= E_PICK;
        end
    end

    // Toggle bit: flips on each status read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)              tog <= 1'b0;
        else if (rd_en && !ready) tog <= ~tog;
    end

    assign ready  = (mode == M_READ) || (mode == M_SUSP);
    assign status = {ready, tog, 6'b0};

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_sector) && $stable(eng_op)));
    assert_req_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> mask_bits[eng_sector]);
    assert_quiet_outside_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != M_RUN) |-> !eng_req);
    assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ready) |=> status[6] != $past(status[6]));
    assert_window_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_WINDOW) |-> win_active);
endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
    localparam int T = 125;   // 125 MHz * 1 us

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [13:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  protect = 8'b0000_0010;
    logic        eng_done = 1'b0;
    logic        ready, eng_req, eng_op;
    logic [7:0]  status;
    logic [2:0]  eng_sector;

    int checks = 0;
    int fails = 0;
    int resp_count = 0;
    bit finished = 1'b0;
    logic [3:0] exp_q[$];

    always #4 clk = ~clk;

    flash_erase_seq #(.WINDOW_US(1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .protect(protect),
        .eng_done(eng_done), .ready(ready), .status(status),
        .eng_req(eng_req), .eng_op(eng_op), .eng_sector(eng_sector)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic erase_seq(input logic [2:0] s, input logic [10:0] off);
        wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h80);
        wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr({s, off}, 8'h30);
    endtask

    task automatic expect_sector(input logic [2:0] s);
        exp_q.push_back({1'b0, s});
        exp_q.push_back({1'b1, s});
    endtask

    task automatic wait_ready(input int limit);
        for (int i = 0; i < limit && ready !== 1'b1; i++) @(negedge clk);
    endtask

    // Monitor/responder: pops the expected step and answers with done.
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req === 1'b1) begin
                resp_count++;
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6 unexpected request actual=%0h expected=none",
                             {eng_op, eng_sector});
                end else begin
                    chk("R6 step order", int'({eng_op, eng_sector}), int'(exp_q.pop_front()));
                end
                repeat (3) @(negedge clk);
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", ready, 1);
        chk("R1 req", eng_req, 0);
        chk("R1 status", status, 8'h80);

        // R3 broken sequence
        wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h80);
        wr(14'h0555, 8'hA0); wr(14'h02AA, 8'h55); wr({3'd2, 11'h000}, 8'h30);
        chk("R3 ready after abort", ready, 1);
        repeat (T + 5) @(negedge clk);
        chk("R3 no request", resp_count, 0);
        chk("R3 still ready", ready, 1);

        // R2/R4/R5/R7/R9 main run: sectors 5, 1(protected), 3
        expect_sector(3'd3); expect_sector(3'd5);
        erase_seq(3'd5, 11'h123);
        chk("R2 busy after sequence", ready, 0);
        chk("R9 poll bit busy", status[7], 0);
        old = status[6];
        rd();
        chk("R9 toggle flip 1", status[6], old ^ 1);
        rd();
        chk("R9 toggle flip 2", status[6], old);
        chk("R9 low bits", status[5:0], 0);
        wr({3'd1, 11'h010}, 8'h30);
        wr({3'd3, 11'h7FF}, 8'h30);
        repeat (T - 3) @(negedge clk);
        chk("R5 restarted window", eng_req, 0);
        wr({3'd0, 11'h000}, 8'hF0);
        repeat (T) @(negedge clk);
        chk("R5 not yet", eng_req, 0);
        chk("R5 busy in window", ready, 0);
        @(negedge clk);
        chk("R5 first request due", eng_req, 1);
        // R8 ignored writes during the run
        erase_seq(3'd7, 11'h000);
        wr({3'd6, 11'h000}, 8'h30);
        wait_ready(5000);
        chk("R10 ready after run", ready, 1);
        chk("R6 queue drained", exp_q.size(), 0);
        chk("R8 sector 7 ignored", resp_count, 4);
        old = status[6];
        rd();
        chk("R9 toggle holds when ready", status[6], old);

        // R7 only a protected sector
        erase_seq(3'd1, 11'h000);
        repeat (T + 4) @(negedge clk);
        chk("R7 empty mask finishes", ready, 1);
        chk("R7 no request", resp_count, 4);

        // R10 mask cleared: only sector 0 now
        expect_sector(3'd0);
        erase_seq(3'd0, 11'h321);
        @(negedge clk);
        wait_ready(5000);
        chk("R10 only new sector", resp_count, 6);
        chk("R10 queue drained", exp_q.size(), 0);

        // R8 suspend and resume: sectors 2 and 6
        expect_sector(3'd2); expect_sector(3'd6);
        erase_seq(3'd6, 11'h0AA);
        wr({3'd2, 11'h055}, 8'h30);
        for (int i = 0; i < 5000 && eng_req !== 1'b1; i++) @(negedge clk);
        wr(14'h0000, 8'hB0);
        wait_ready(5000);
        chk("R8 suspended ready", ready, 1);
        wr(14'h0555, 8'h80);
        repeat (20) @(negedge clk);
        chk("R8 held while suspended", eng_req, 0);
        chk("R8 one step done", resp_count, 7);
        chk("R8 steps left", exp_q.size(), 3);
        chk("R8 still suspended", ready, 1);
        wr(14'h0000, 8'h30);
        chk("R8 resumed busy", ready, 0);
        wait_ready(5000);
        chk("R8 resumed to end", exp_q.size(), 0);
        chk("R8 total steps", resp_count, 10);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule